// File: doc/BRIEF.md
# RGB Pixel Line Formatter

This block takes parallel 18-bit pixels (three 6-bit channels) sampled on a free-running dot clock and assembles them into one source-line register of 528 six-bit columns, holding 176 pixels of three columns each. An active-high enable qualifies every pixel, so data presented during porch periods is dropped. Each accepted pixel is shaped on its way into the line register. Its channels can be placed blue-first instead of red-first, the most significant bit of each channel can be spread across the whole channel for an 8-colour picture, and every channel can be inverted for panels that want the opposite drive polarity.

The line can be filled from column 0 upward or from column 527 downward. When the 176th enabled pixel of a line arrives, a one-cycle line-ready strobe marks the completed line on the output bus. A gate-line index then steps toward the far end of a 220-line frame, in the direction that a scan input selects. When the index wraps it raises a frame-done strobe. If enable drops in the middle of a line, the pixel position returns to the start of the line, so a short line is never continued by the next one.

Top module: `rgb_line_fmt`

## Requirements
- R1: While rst is high and on the cycle after it falls, line_data is all zeros, line_ready and frame_done are low, and gate_idx is 0 when scan_rev is 0 or 219 when scan_rev is 1.
- R2: A pixel is captured only on a rising clk edge where pix_en is high. Edges with pix_en low change neither line_data nor the pixel position.
- R3: With fill_rev low, the three channels of the p-th captured pixel of a line (p from 0) go to columns 3p, 3p+1 and 3p+2 in that order. Column c occupies line_data bits [6c+5:6c].
- R4: With fill_rev high, the three channels of the p-th pixel go to columns 527-3p, 526-3p and 525-3p in that order.
- R5: With bgr low the channel order is red, green, blue. With bgr high it is blue, green, red.
- R6: With rev high, every 6-bit channel value written is the bitwise inverse of the shaped input channel.
- R7: With mono high, each channel becomes 6'h3F if its bit 5 is set and 6'h00 otherwise. Inversion under R6 is applied after this step.
- R8: The clock edge that captures the 176th pixel of a line raises line_ready for exactly one cycle, and line_data then holds the complete line. The next pixel is again pixel 0.
- R9: A rising clk edge with pix_en low that follows an edge with pix_en high returns the pixel position to 0. The next captured pixel lands at the first position of a line.
- R10: Each line completion moves gate_idx by one in the cycle line_ready is high: up when scan_rev is 0, down when scan_rev is 1. At all other times gate_idx holds.
- R11: A line completion while gate_idx is at the last line (219 going up, 0 going down) reloads the start value (0 or 219) and raises frame_done for one cycle, together with line_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; runs continuously |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel qualifier; high marks valid data |
| pix_r | input | 6 | Red channel |
| pix_g | input | 6 | Green channel |
| pix_b | input | 6 | Blue channel |
| bgr | input | 1 | 1: blue-first channel order |
| rev | input | 1 | 1: invert every channel |
| mono | input | 1 | 1: 8-colour reduction from channel MSBs |
| fill_rev | input | 1 | 1: fill from column 527 downward |
| scan_rev | input | 1 | 1: gate index counts down from 219 |
| line_data | output | 3168 | 528 columns of 6 bits, column c at bits 6c+5..6c |
| line_ready | output | 1 | One-cycle strobe: line complete |
| gate_idx | output | 8 | Current gate line, 0 to 219 |
| frame_done | output | 1 | One-cycle strobe: gate index wrapped |

## Verification
The bound checker checks these properties on every cycle: the line is frozen on edges without enable, both strobes last one cycle and frame-done always coincides with line-ready, the gate index stays in range, holds between completions and steps or wraps correctly. Column placement, channel order, inversion, 8-colour reduction and the position reset on a falling enable depend on pixel values and history, so only the bench scenarios can show them. In those scenarios, every captured pixel is compared column by column against an independently computed line, over full frames in both scan directions and with the shaping modes changed at random from line to line.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

    // width of one colour channel
    localparam int CH_W       = 6;
    // channels per pixel (columns per pixel)
    localparam int CH_PER_PIX = 3;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } pixel_t;

    // channels in the order they are laid into consecutive columns
    typedef struct packed {
        chan_t first;
        chan_t mid;
        chan_t last;
    } triplet_t;

    typedef enum logic {
        ORDER_RGB = 1'b0,
        ORDER_BGR = 1'b1
    } order_e;

    typedef struct packed {
        order_e order;
        logic   invert;
        logic   reduce;
    } shape_t;

    // 8-colour reduction followed by optional polarity inversion
    function automatic chan_t shape_chan(chan_t v, logic invert, logic reduce);
        chan_t t;
        t = reduce ? {CH_W{v[CH_W-1]}} : v;
        return invert ? ~t : t;
    endfunction

    function automatic triplet_t order_pixel(pixel_t p, order_e order);
        triplet_t t;
        t.mid   = p.g;
        t.first = (order == ORDER_BGR) ? p.b : p.r;
        t.last  = (order == ORDER_BGR) ? p.r : p.b;
        return t;
    endfunction

endpackage

// File: rtl/pixel_shaper.sv
module pixel_shaper
    import rgbfmt_pkg::*;
(
    input  pixel_t   pix,
    input  shape_t   shape,
    output triplet_t trip
);
    triplet_t ordered;

    always_comb begin
        ordered     = order_pixel(pix, shape.order);
        trip.first  = shape_chan(ordered.first, shape.invert, shape.reduce);
        trip.mid    = shape_chan(ordered.mid,   shape.invert, shape.reduce);
        trip.last   = shape_chan(ordered.last,  shape.invert, shape.reduce);
    end
endmodule

// File: rtl/line_writer.sv
module line_writer
    import rgbfmt_pkg::*;
#(
    parameter int PIX_PER_LINE = 176
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       en,
    input  logic                                       fill_rev,
    input  triplet_t                                   trip,
    output logic [PIX_PER_LINE*CH_PER_PIX*CH_W-1:0]   line_data,
    output logic                                       last_pix,
    output logic                                       line_done
);
    localparam int COLS  = PIX_PER_LINE * CH_PER_PIX;
    localparam int IDX_W = $clog2(PIX_PER_LINE);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_LINE - 1);

    logic [IDX_W-1:0]           idx_q;
    logic                       en_q;
    logic [COLS-1:0][CH_W-1:0]  line_q;

    assign last_pix  = en && (idx_q == LAST_IDX);
    assign line_data = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            en_q      <= 1'b0;
            line_done <= 1'b0;
        end else begin
            en_q      <= en;
            line_done <= last_pix;
            if (en) begin
                idx_q <= last_pix ? '0 : idx_q + 1'b1;
            end else if (en_q) begin
                idx_q <= '0;
            end
        end
    end

    // each column knows which pixel and which channel slot feed it
    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam logic [IDX_W-1:0] FWD_PIX = IDX_W'(c / CH_PER_PIX);
        localparam int               FWD_SUB = c % CH_PER_PIX;
        localparam logic [IDX_W-1:0] REV_PIX = IDX_W'((COLS - 1 - c) / CH_PER_PIX);
        localparam int               REV_SUB = (COLS - 1 - c) % CH_PER_PIX;

        logic  hit;
        int    sub;
        chan_t val;

        always_comb begin
            hit = en && (fill_rev ? (idx_q == REV_PIX) : (idx_q == FWD_PIX));
            sub = fill_rev ? REV_SUB : FWD_SUB;
            case (sub)
                0:       val = trip.first;
                1:       val = trip.mid;
                default: val = trip.last;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[c] <= '0;
            end else if (hit) begin
                line_q[c] <= val;
            end
        end
    end
endmodule

// File: rtl/gate_stepper.sv
module gate_stepper #(
    parameter int LINES = 220,
    localparam int GATE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_rev,
    input  logic              step,
    output logic [GATE_W-1:0] gate_idx,
    output logic              frame_done
);
    localparam logic [GATE_W-1:0] TOP = GATE_W'(LINES - 1);

    logic [GATE_W-1:0] start_v;
    logic [GATE_W-1:0] end_v;
    logic              at_end;

    always_comb begin
        start_v = scan_rev ? TOP : '0;
        end_v   = scan_rev ? '0  : TOP;
        at_end  = (gate_idx == end_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_idx   <= start_v;
            frame_done <= 1'b0;
        end else begin
            frame_done <= step && at_end;
            if (step) begin
                if (at_end)        gate_idx <= start_v;
                else if (scan_rev) gate_idx <= gate_idx - 1'b1;
                else               gate_idx <= gate_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rgb_line_fmt.sv
module rgb_line_fmt
    import rgbfmt_pkg::*;
#(
    parameter int PIX_PER_LINE = 176,
    parameter int LINES        = 220,
    localparam int LINE_W      = PIX_PER_LINE * CH_PER_PIX * CH_W,
    localparam int GATE_W      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic [CH_W-1:0]   pix_r,
    input  logic [CH_W-1:0]   pix_g,
    input  logic [CH_W-1:0]   pix_b,
    input  logic              bgr,
    input  logic              rev,
    input  logic              mono,
    input  logic              fill_rev,
    input  logic              scan_rev,
    output logic [LINE_W-1:0] line_data,
    output logic              line_ready,
    output logic [GATE_W-1:0] gate_idx,
    output logic              frame_done
);
    pixel_t   pix;
    shape_t   shape;
    triplet_t trip;
    logic     last_pix;

    always_comb begin
        pix.r        = pix_r;
        pix.g        = pix_g;
        pix.b        = pix_b;
        shape.order  = bgr ? ORDER_BGR : ORDER_RGB;
        shape.invert = rev;
        shape.reduce = mono;
    end

    pixel_shaper u_shaper (
        .pix   (pix),
        .shape (shape),
        .trip  (trip)
    );

    line_writer #(
        .PIX_PER_LINE (PIX_PER_LINE)
    ) u_writer (
        .clk       (clk),
        .rst       (rst),
        .en        (pix_en),
        .fill_rev  (fill_rev),
        .trip      (trip),
        .line_data (line_data),
        .last_pix  (last_pix),
        .line_done (line_ready)
    );

    gate_stepper #(
        .LINES (LINES)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .scan_rev   (scan_rev),
        .step       (last_pix),
        .gate_idx   (gate_idx),
        .frame_done (frame_done)
    );
endmodule

// File: rtl/rgb_line_fmt_chk.sv
module rgb_line_fmt_chk #(
    parameter int LINE_W = 3168,
    parameter int LINES  = 220,
    localparam int GATE_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_en,
    input logic              scan_rev,
    input logic [LINE_W-1:0] line_data,
    input logic              line_ready,
    input logic [GATE_W-1:0] gate_idx,
    input logic              frame_done
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(line_data));

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        line_ready |=> !line_ready);

    // R11
    frame_with_line_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> line_ready);

    // R10
    gate_range_chk: assert property (@(posedge clk) disable iff (rst)
        gate_idx < GATE_W'(LINES));

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_ready |-> gate_idx == $past(gate_idx));

    // R10
    gate_up_chk: assert property (@(posedge clk) disable iff (rst)
        (line_ready && !frame_done && !scan_rev) |-> gate_idx == $past(gate_idx) + 1'b1);

    // R10
    gate_down_chk: assert property (@(posedge clk) disable iff (rst)
        (line_ready && !frame_done && scan_rev) |-> gate_idx == $past(gate_idx) - 1'b1);

    // R11
    gate_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> gate_idx == (scan_rev ? GATE_W'(LINES - 1) : '0));
endmodule

bind rgb_line_fmt rgb_line_fmt_chk #(
    .LINE_W (LINE_W),
    .LINES  (LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .scan_rev   (scan_rev),
    .line_data  (line_data),
    .line_ready (line_ready),
    .gate_idx   (gate_idx),
    .frame_done (frame_done)
);

// File: tb/rgb_line_fmt_test.sv
`timescale 1ns/1ps
module rgb_line_fmt_test;
    localparam int PPL   = 176;
    localparam int COLS  = PPL * 3;
    localparam int LINES = 220;
    localparam int LW    = COLS * 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_en = 1'b0;
    logic [5:0]    pix_r = '0, pix_g = '0, pix_b = '0;
    logic          bgr = 1'b0, rev = 1'b0, mono = 1'b0, fill_rev = 1'b0, scan_rev = 1'b0;
    logic [LW-1:0] line_data;
    logic          line_ready;
    logic [7:0]    gate_idx;
    logic          frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model state
    logic [LW-1:0] exp_line;
    int            m_idx;
    int            m_gate;
    logic          m_en_q;
    logic          exp_ready, exp_frame;

    always #2.5 clk = ~clk;   // 200 MHz

    rgb_line_fmt uut (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .bgr(bgr), .rev(rev), .mono(mono), .fill_rev(fill_rev), .scan_rev(scan_rev),
        .line_data(line_data), .line_ready(line_ready),
        .gate_idx(gate_idx), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // R7 then R6: reduce to MSB, then invert
    function automatic logic [5:0] exp_chan(logic [5:0] v, logic inv, logic red);
        logic [5:0] m;
        m = red ? (v[5] ? 6'd63 : 6'd0) : v;
        return inv ? 6'd63 - m : m;
    endfunction

    function automatic logic [5:0] col_of(int c);
        return line_data[c*6 +: 6];
    endfunction

    function automatic logic [5:0] exp_col(int c);
        return exp_line[c*6 +: 6];
    endfunction

    task automatic model_reset();
        exp_line = '0;
        m_idx    = 0;
        m_en_q   = 1'b0;
        m_gate   = scan_rev ? LINES - 1 : 0;
    endtask

    task automatic compare_all();
        int bad;
        bad = -1;
        chk(line_ready == exp_ready, "R8 line_ready", line_ready, exp_ready);
        chk(frame_done == exp_frame, "R11 frame_done", frame_done, exp_frame);
        chk(gate_idx == 8'(m_gate), "R10 gate_idx", gate_idx, m_gate);
        if (line_data !== exp_line) begin
            for (int c = COLS - 1; c >= 0; c--) if (col_of(c) !== exp_col(c)) bad = c;
        end
        chk(bad < 0, "R3/R4/R5/R6/R7 line column", (bad < 0) ? 0 : col_of(bad),
            (bad < 0) ? 0 : exp_col(bad));
    endtask

    // one dot-clock cycle: drive away from the edge, model, then compare
    task automatic step(input logic en, input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
        logic [5:0] ch;
        int col;
        @(negedge clk);
        pix_en = en; pix_r = r; pix_g = g; pix_b = b;
        @(posedge clk);
        #1;
        exp_ready = en && (m_idx == PPL - 1);
        exp_frame = exp_ready && (m_gate == (scan_rev ? 0 : LINES - 1));
        if (en) begin
            for (int k = 0; k < 3; k++) begin
                // R5: order of channels
                if (k == 1)      ch = g;
                else if (k == 0) ch = bgr ? b : r;
                else             ch = bgr ? r : b;
                // R3 / R4: column placement
                col = fill_rev ? (COLS - 1 - 3*m_idx - k) : (3*m_idx + k);
                exp_line[col*6 +: 6] = exp_chan(ch, rev, mono);
            end
            m_idx = exp_ready ? 0 : m_idx + 1;
        end else if (m_en_q) begin
            m_idx = 0;   // R9
        end
        m_en_q = en;
        if (exp_ready) begin
            if (exp_frame)     m_gate = scan_rev ? LINES - 1 : 0;
            else if (scan_rev) m_gate = m_gate - 1;
            else               m_gate = m_gate + 1;
        end
        compare_all();
    endtask

    task automatic do_reset(input logic sr);
        @(negedge clk);
        scan_rev = sr; rst = 1'b1; pix_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: state held during reset
        chk(line_ready == 1'b0 && frame_done == 1'b0, "R1 strobes in reset", {line_ready, frame_done}, 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        #1;
        exp_ready = 1'b0; exp_frame = 1'b0;
        // R1
        chk(line_data == '0, "R1 line_data zero", line_data[63:0], 0);
        chk(gate_idx == 8'(m_gate), "R1 gate start", gate_idx, m_gate);
        chk(!line_ready && !frame_done, "R1 strobes low", {line_ready, frame_done}, 0);
    endtask

    task automatic random_modes(input logic allow_fill);
        bgr  = 1'($urandom);
        rev  = 1'($urandom);
        mono = ($urandom % 4) == 0;
        if (allow_fill) fill_rev = 1'($urandom);
    endtask

    task automatic full_line();
        random_modes(1'b1);
        for (int p = 0; p < PPL; p++)
            step(1'b1, 6'($urandom), 6'($urandom), 6'($urandom));
        // R8: strobe seen at the completing pixel
        chk(exp_ready && line_ready, "R8 strobe on last pixel", line_ready, 1);
        repeat ($urandom % 4) step(1'b0, 6'($urandom), 6'($urandom), 6'($urandom));
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        exp_ready = 1'b0; exp_frame = 1'b0;
        do_reset(1'b0);

        // R7: 8-colour reduction
        mono = 1'b1;
        step(1'b1, 6'h20, 6'h1F, 6'h3F);
        chk(col_of(0) == 6'h3F && col_of(1) == 6'h00 && col_of(2) == 6'h3F, "R7 mono pixel",
            {col_of(0), col_of(1), col_of(2)}, 18'h3F03F);
        // R6: inversion
        mono = 1'b0; rev = 1'b1;
        step(1'b1, 6'h05, 6'h2A, 6'h00);
        chk(col_of(3) == 6'h3A && col_of(4) == 6'h15 && col_of(5) == 6'h3F, "R6 inverted pixel",
            {col_of(3), col_of(4), col_of(5)}, {6'h3A, 6'h15, 6'h3F});
        // R5: blue-first order
        rev = 1'b0; bgr = 1'b1;
        step(1'b1, 6'h11, 6'h22, 6'h33);
        chk(col_of(6) == 6'h33 && col_of(8) == 6'h11, "R5 bgr order",
            {col_of(6), col_of(8)}, {6'h33, 6'h11});
        bgr = 1'b0;
        step(1'b1, 6'h01, 6'h02, 6'h03);
        chk(col_of(9) == 6'h01 && col_of(11) == 6'h03, "R3 forward slot 3",
            {col_of(9), col_of(11)}, {6'h01, 6'h03});

        // R2: disabled cycles change nothing
        for (int i = 0; i < 6; i++) step(1'b0, 6'($urandom), 6'($urandom), 6'($urandom));
        chk(col_of(12) == 6'h00, "R2 no capture while disabled", col_of(12), 0);

        // R9: falling enable restarted the line, next pixel at column 0
        step(1'b1, 6'h2C, 6'h0D, 6'h1E);
        chk(col_of(0) == 6'h2C && col_of(12) == 6'h00, "R9 restart at slot 0",
            {col_of(0), col_of(12)}, {6'h2C, 6'h00});
        step(1'b0, 6'h00, 6'h00, 6'h00);

        // R4: reverse fill lands at the top column
        fill_rev = 1'b1;
        step(1'b1, 6'h07, 6'h08, 6'h09);
        chk(col_of(527) == 6'h07 && col_of(525) == 6'h09, "R4 reverse slot 0",
            {col_of(527), col_of(525)}, {6'h07, 6'h09});
        step(1'b1, 6'h0A, 6'h0B, 6'h0C);
        chk(col_of(524) == 6'h0A && col_of(522) == 6'h0C, "R4 reverse slot 1",
            {col_of(524), col_of(522)}, {6'h0A, 6'h0C});
        step(1'b0, 6'h3F, 6'h3F, 6'h3F);

        // full frame, gate counting upward, plus one line past the wrap (R10, R11)
        for (int l = 0; l < LINES + 1; l++) full_line();

        // full frame, gate counting downward
        do_reset(1'b1);
        for (int l = 0; l < LINES + 1; l++) full_line();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule